// File: doc/BRIEF.md
# Adaptive Delta Modulation Codec

This block turns a stream of signed multi-bit samples into a one-bit-per-sample difference stream, and turns such a bit stream back into a staircase estimate of the original signal. The encoder compares each accepted sample with its own running estimate. It emits a 1 when the sample is at or above the estimate and a 0 when it is below. It then moves the estimate up or down by the current step.

The step is adaptive. A run of identical bits makes it larger, so that the estimate can follow steep slopes. Two differing consecutive bits make it smaller, so that the estimate hunts less around a slow input. The decoder holds an identical estimate-and-step tracker fed only by the received bits. When it is given the encoder's bits it reproduces the encoder's estimate sample for sample.

All four data paths use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. Each output keeps one registered result. An output that is valid and not ready holds its value and stalls its input by pulling that input's ready low. Input ready is high whenever the output register is empty or is being drained in the same cycle. Nothing changes state without an accepted transfer.

Top module: `adm_codec`

## Requirements
- R1: The encoder bit for an accepted sample is 1 when the signed sample is greater than or equal to the encoder's current estimate, and 0 when it is smaller.
- R2: Every accepted sample yields exactly one bit. The bit is presented with `enc_valid` high from the cycle after the acceptance edge.
- R3: On each accepted bit, a tracker's estimate rises by the step in force before that bit when the bit is 1, and falls by that step when it is 0.
- R4: When the current bit and the RUN_LEN-1 bits before it are all equal (RUN_LEN defaults to 3), the step for the next sample doubles, but never above STEP_MAX (default 256). This applies only once RUN_LEN-1 bits have been taken since reset.
- R5: When the current bit differs from the previous bit, the step for the next sample halves, but never below STEP_MIN (default 4).
- R6: In every other case, including the first bits after reset, the step stays unchanged.
- R7: The estimate saturates at the signed full-scale limits (+2047 and -2048 for the 12-bit default) instead of wrapping.
- R8: After reset both estimates are 0, both steps equal STEP_MIN, the bit history is empty, both output valids are low and both input readies are high.
- R9: While an output is valid and not ready, its data is held, its input's ready is low, and input offered on that path is not taken.
- R10: The decoder's estimate after each accepted received bit is presented on `dec_out_est` with `dec_out_valid` from the next cycle. When it is fed the encoder's bit stream, it equals the encoder's estimate after the same sample.
- R11: Cycles without an accepted transfer change no estimate, step or history, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered to the encoder |
| in_ready | output | 1 | Encoder can take a sample |
| in_sample | input | SAMPLE_W | Signed two's-complement sample |
| enc_valid | output | 1 | Encoded bit available |
| enc_ready | input | 1 | Consumer takes the encoded bit |
| enc_bit | output | 1 | Encoded bit (1 = sample at or above estimate) |
| rx_valid | input | 1 | Received bit offered to the decoder |
| rx_ready | output | 1 | Decoder can take a bit |
| rx_bit | input | 1 | Received bit |
| dec_out_valid | output | 1 | Reconstructed estimate available |
| dec_out_ready | input | 1 | Consumer takes the estimate |
| dec_out_est | output | SAMPLE_W | Signed reconstructed estimate |

## Verification
Step doubling and estimate saturation can fall on the same sample. In that case the estimate must be clamped using the pre-doubling step, while the step still grows up to its ceiling. The bench provokes this by holding the input at positive and then negative full scale, so that long runs of identical bits drive the estimate into its limit while the step is still rising. It judges the outcome by comparing the decoder's estimate, sample by sample, with a reference model and with the encoder's reconstructed estimate. A second collision is a drain and a new acceptance in the same edge; it is exercised by releasing back-pressure while further samples wait.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef enum logic [1:0] {
    ADAPT_HOLD   = 2'd0,
    ADAPT_GROW   = 2'd1,
    ADAPT_SHRINK = 2'd2
  } adapt_e;
endpackage

// File: rtl/adm_pattern.sv
module adm_pattern #(
  parameter int RUN_LEN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            bit_in,
  output adm_pkg::adapt_e kind
);
  localparam int HW = RUN_LEN - 1;
  localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] FULL = CW'(HW);

  logic [HW-1:0] hist;
  logic [HW-1:0] hist_nxt;
  logic [HW-1:0] match;
  logic [CW-1:0] fill;

  // each remembered bit compared with the incoming one
  for (genvar i = 0; i < HW; i++) begin : g_match
    assign match[i] = (hist[i] == bit_in);
  end

  always_comb begin
    hist_nxt    = hist << 1;
    hist_nxt[0] = bit_in;
  end

  // R4 R5 R6: run, alternation or neither
  always_comb begin
    if (fill == FULL && (&match))
      kind = adm_pkg::ADAPT_GROW;
    else if (fill != '0 && !match[0])
      kind = adm_pkg::ADAPT_SHRINK;
    else
      kind = adm_pkg::ADAPT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      fill <= '0;
    end else if (adv) begin
      hist <= hist_nxt;
      if (fill != FULL) fill <= fill + 1'b1;
    end
  end

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);

  // R11
  hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(hist) && $stable(fill));

  // R4
  grow_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind == adm_pkg::ADAPT_GROW |-> fill == FULL);
endmodule

// File: rtl/adm_step_ctl.sv
module adm_step_ctl #(
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 256,
  parameter int STEP_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  adm_pkg::adapt_e     kind,
  output logic [STEP_W-1:0]   step
);
  localparam logic [STEP_W-1:0] MIN_V  = STEP_W'(STEP_MIN);
  localparam logic [STEP_W:0]   MAX_VW = (STEP_W+1)'(STEP_MAX);

  logic [STEP_W:0]   dbl;
  logic [STEP_W-1:0] grown;
  logic [STEP_W-1:0] half;
  logic [STEP_W-1:0] shrunk;

  // R4: ceiling applied to the doubled step
  always_comb begin
    dbl   = {1'b0, step} << 1;
    grown = (dbl > MAX_VW) ? MAX_VW[STEP_W-1:0] : dbl[STEP_W-1:0];
  end

  // R5: floor applied to the halved step
  always_comb begin
    half   = step >> 1;
    shrunk = (half < MIN_V) ? MIN_V : half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= MIN_V;
    end else if (adv) begin
      unique case (kind)
        adm_pkg::ADAPT_GROW:   step <= grown;
        adm_pkg::ADAPT_SHRINK: step <= shrunk;
        default:               step <= step;
      endcase
    end
  end

  // R4 R5
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step >= MIN_V && {1'b0, step} <= MAX_VW);

  // R4
  grow_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && kind == adm_pkg::ADAPT_GROW |=> step >= $past(step));

  // R5
  shrink_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && kind == adm_pkg::ADAPT_SHRINK |=> step <= $past(step));

  // R6
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && kind == adm_pkg::ADAPT_HOLD |=> $stable(step));

  // R11
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(step));
endmodule

// File: rtl/adm_accum.sv
module adm_accum #(
  parameter int SAMPLE_W = 12,
  parameter int STEP_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                up,
  input  logic [STEP_W-1:0]   step,
  output logic [SAMPLE_W-1:0] est
);
  localparam logic signed [SAMPLE_W:0] POS_LIM = {2'b00, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W:0] NEG_LIM = {2'b11, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W:0] wide;
  logic signed [SAMPLE_W:0] delta;
  logic signed [SAMPLE_W:0] sum;
  logic [SAMPLE_W-1:0]      est_nxt;

  // R3: one guard bit holds the unclamped sum
  always_comb begin
    wide  = {est[SAMPLE_W-1], est};
    delta = {{(SAMPLE_W+1-STEP_W){1'b0}}, step};
    sum   = up ? (wide + delta) : (wide - delta);
  end

  // R7: clamp to full scale
  always_comb begin
    if (sum > POS_LIM)
      est_nxt = POS_LIM[SAMPLE_W-1:0];
    else if (sum < NEG_LIM)
      est_nxt = NEG_LIM[SAMPLE_W-1:0];
    else
      est_nxt = sum[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) est <= '0;
    else if (adv) est <= est_nxt;
  end

  // R3 R7
  rise_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && up |=> $signed(est) >= $signed($past(est)));

  // R3 R7
  fall_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !up |=> $signed(est) <= $signed($past(est)));

  // R11
  idle_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(est));
endmodule

// File: rtl/adm_track.sv
module adm_track #(
  parameter int SAMPLE_W = 12,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 256,
  parameter int STEP_W   = 9,
  parameter int RUN_LEN  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                bit_in,
  output logic [SAMPLE_W-1:0] est
);
  adm_pkg::adapt_e   kind;
  logic [STEP_W-1:0] step;

  adm_pattern #(.RUN_LEN(RUN_LEN)) pat_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .bit_in(bit_in), .kind(kind)
  );

  adm_step_ctl #(.STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_W(STEP_W)) stp_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .kind(kind), .step(step)
  );

  adm_accum #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .up(bit_in), .step(step), .est(est)
  );
endmodule

// File: rtl/adm_codec.sv
module adm_codec #(
  parameter int SAMPLE_W = 12,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 256,
  parameter int RUN_LEN  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                enc_valid,
  input  logic                enc_ready,
  output logic                enc_bit,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic                rx_bit,
  output logic                dec_out_valid,
  input  logic                dec_out_ready,
  output logic [SAMPLE_W-1:0] dec_out_est
);
  localparam int STEP_W = $clog2(STEP_MAX + 1);

  logic [SAMPLE_W-1:0] enc_est;
  logic [SAMPLE_W-1:0] dec_est;
  logic enc_fire, dec_fire, enc_cmp;
  logic enc_valid_q, enc_bit_q, dec_valid_q;

  // R9: one-entry output, drain and refill may share an edge
  assign in_ready = !enc_valid_q || enc_ready;
  assign rx_ready = !dec_valid_q || dec_out_ready;
  assign enc_fire = in_valid && in_ready;
  assign dec_fire = rx_valid && rx_ready;

  // R1: ties count as a rise
  assign enc_cmp = ($signed(in_sample) >= $signed(enc_est));

  adm_track #(
    .SAMPLE_W(SAMPLE_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
    .STEP_W(STEP_W), .RUN_LEN(RUN_LEN)
  ) enc_trk_i (
    .clk(clk), .rst_n(rst_n), .adv(enc_fire), .bit_in(enc_cmp), .est(enc_est)
  );

  // R10: same tracker driven by received bits
  adm_track #(
    .SAMPLE_W(SAMPLE_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
    .STEP_W(STEP_W), .RUN_LEN(RUN_LEN)
  ) dec_trk_i (
    .clk(clk), .rst_n(rst_n), .adv(dec_fire), .bit_in(rx_bit), .est(dec_est)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_valid_q <= 1'b0;
      enc_bit_q   <= 1'b0;
    end else if (enc_fire) begin
      enc_valid_q <= 1'b1;
      enc_bit_q   <= enc_cmp;
    end else if (enc_ready) begin
      enc_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_valid_q <= 1'b0;
    else if (dec_fire) dec_valid_q <= 1'b1;
    else if (dec_out_ready) dec_valid_q <= 1'b0;
  end

  assign enc_valid     = enc_valid_q;
  assign enc_bit       = enc_bit_q;
  assign dec_out_valid = dec_valid_q;
  assign dec_out_est   = dec_est;

  // R2
  enc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_fire |=> enc_valid);

  // R10
  dec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> dec_out_valid);

  // R9
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid && !enc_ready |=> enc_valid && $stable(enc_bit));

  // R9
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_est));
endmodule

// File: tb/adm_codec_tb_top.sv
module adm_codec_tb_top;
  localparam int W = 12;
  localparam int SMIN = 4;
  localparam int SMAX = 256;
  localparam int RUN = 3;
  localparam int PLIM = 2047;
  localparam int NLIM = -2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, enc_ready = 1'b1, rx_valid = 1'b0, rx_bit = 1'b0, dec_out_ready = 1'b1;
  logic [W-1:0] in_sample = '0;
  logic in_ready, enc_valid, enc_bit, rx_ready, dec_out_valid;
  logic [W-1:0] dec_out_est;

  int total = 0;
  int bad = 0;
  int m_est[2], m_step[2], m_fill[2], m_hist[2];

  always #10 clk = ~clk;

  adm_codec #(.SAMPLE_W(W), .STEP_MIN(SMIN), .STEP_MAX(SMAX), .RUN_LEN(RUN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .enc_valid(enc_valid), .enc_ready(enc_ready),
    .enc_bit(enc_bit), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
    .dec_out_est(dec_out_est)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dec_val();
    return int'($signed(dec_out_est));
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_est[k] = 0; m_step[k] = SMIN; m_fill[k] = 0; m_hist[k] = 0;
    end
  endtask

  task automatic model_adv(input int k, input bit b);
    int ne;
    bit same;
    ne = b ? m_est[k] + m_step[k] : m_est[k] - m_step[k];
    if (ne > PLIM) ne = PLIM;
    if (ne < NLIM) ne = NLIM;
    same = 1'b1;
    for (int i = 0; i < RUN - 1; i++)
      if (((m_hist[k] >> i) & 1) != int'(b)) same = 1'b0;
    if (m_fill[k] == RUN - 1 && same)
      m_step[k] = (2 * m_step[k] > SMAX) ? SMAX : 2 * m_step[k];
    else if (m_fill[k] > 0 && (m_hist[k] & 1) != int'(b))
      m_step[k] = (m_step[k] / 2 < SMIN) ? SMIN : m_step[k] / 2;
    m_hist[k] = ((m_hist[k] << 1) | int'(b)) & ((1 << (RUN - 1)) - 1);
    if (m_fill[k] < RUN - 1) m_fill[k]++;
    m_est[k] = ne;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; rx_valid = 1'b0;
    enc_ready = 1'b1; dec_out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic enc_send(input int s, output bit got);
    bit exp;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    in_valid = 1'b1; in_sample = s[W-1:0];
    @(negedge clk);
    in_valid = 1'b0;
    exp = (s >= m_est[0]);
    chk(enc_valid == 1'b1, "R2 enc_valid", int'(enc_valid), 1);
    chk(enc_bit == exp, "R1 enc_bit", int'(enc_bit), int'(exp));
    got = enc_bit;
    model_adv(0, exp);
  endtask

  task automatic dec_send(input bit b);
    @(negedge clk);
    rx_valid = 1'b1; rx_bit = b;
    @(negedge clk);
    rx_valid = 1'b0;
    model_adv(1, b);
    chk(dec_out_valid == 1'b1, "R10 dec_out_valid", int'(dec_out_valid), 1);
    chk(dec_val() == m_est[1], "R3 dec_out_est", dec_val(), m_est[1]);
  endtask

  task automatic loop_pair(input int s);
    bit b;
    enc_send(s, b);
    dec_send(b);
    chk(dec_val() == m_est[0], "R10 lockstep", dec_val(), m_est[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int walk;
    int exp_seq[7];
    bit seq[7];
    bit held;
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    @(negedge clk);
    chk(enc_valid == 1'b0, "R8 enc_valid", int'(enc_valid), 0);
    chk(dec_out_valid == 1'b0, "R8 dec_out_valid", int'(dec_out_valid), 0);
    chk(dec_val() == 0, "R8 dec_out_est", dec_val(), 0);
    chk(in_ready && rx_ready, "R8 ready", int'(in_ready & rx_ready), 1);

    // R4 R5 R6: known bit pattern, literal estimates
    seq = '{1, 1, 1, 1, 1, 0, 1};
    exp_seq = '{4, 8, 12, 20, 36, 4, 20};
    for (int i = 0; i < 7; i++) begin
      dec_send(seq[i]);
      chk(dec_val() == exp_seq[i], "R4 R5 R6 staircase", dec_val(), exp_seq[i]);
    end

    // R1 tie at estimate 0 gives 1
    do_reset();
    loop_pair(0);
    chk(enc_bit == 1'b1, "R1 tie", int'(enc_bit), 1);

    // R7 positive full scale with growing step
    for (int i = 0; i < 20; i++) loop_pair(PLIM);
    chk(dec_val() == PLIM, "R7 positive clamp", dec_val(), PLIM);
    // R7 negative full scale
    for (int i = 0; i < 25; i++) loop_pair(NLIM);
    chk(dec_val() == NLIM, "R7 negative clamp", dec_val(), NLIM);

    // R5 constant input settles with minimum step
    for (int i = 0; i < 60; i++) loop_pair(100);
    chk(dec_val() >= 100 - 2*SMIN && dec_val() <= 100 + 2*SMIN,
        "R5 granular settle", dec_val(), 100);

    // R9 encoder back-pressure, offered sample must be ignored
    enc_ready = 1'b0;
    enc_send(500, held);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_sample = 12'(-500);
      @(negedge clk);
      chk(in_ready == 1'b0, "R9 in_ready stall", int'(in_ready), 0);
      chk(enc_valid && enc_bit == held, "R9 enc hold", int'(enc_bit), int'(held));
    end
    in_valid = 1'b0; enc_ready = 1'b1;
    @(negedge clk);
    chk(enc_valid == 1'b0, "R9 drained", int'(enc_valid), 0);
    // R9 decoder back-pressure
    dec_out_ready = 1'b0;
    dec_send(held);
    for (int i = 0; i < 3; i++) begin
      rx_valid = 1'b1; rx_bit = ~held;
      @(negedge clk);
      chk(rx_ready == 1'b0, "R9 rx_ready stall", int'(rx_ready), 0);
      chk(dec_val() == m_est[1], "R9 dec hold", dec_val(), m_est[1]);
    end
    rx_valid = 1'b0; dec_out_ready = 1'b1;
    @(negedge clk);
    chk(dec_val() == m_est[0], "R10 lockstep after stall", dec_val(), m_est[0]);

    // R11 idle cycles with toggling data
    for (int i = 0; i < 6; i++) begin
      rx_bit = ~rx_bit; in_sample = 12'($urandom);
      @(negedge clk);
    end
    chk(dec_val() == m_est[1], "R11 idle estimate", dec_val(), m_est[1]);
    loop_pair(-300);

    // random mix: full-scale jumps and slow walks
    walk = 0;
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) == 0) begin
        walk = int'($urandom % 4096) - 2048;
      end else begin
        walk = walk + int'($urandom % 65) - 32;
        if (walk > PLIM) walk = PLIM;
        if (walk < NLIM) walk = NLIM;
      end
      loop_pair(walk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule